// File: doc/BRIEF.md
# Phase-Frequency Detector With Digital Lock Indication

This block measures the timing relation between the rising edges of two slow square waves: a divided reference clock and a divided feedback clock taken from a synthesizer loop. Both waves are sampled in a faster system clock domain. The block drives two active-low correction pulses, `up_n` and `dn_n`. `up_n` asks the loop for a higher oscillator frequency. `dn_n` asks for a lower one. The width of each pulse, counted in sample-clock cycles, grows in step with the phase error.

Each input passes through a synchronizer and a rising-edge detector. The two edge strobes set a pair of flags. When both flags are set, they clear together on the next sample cycle. Because of this, a matched pair of edges produces only a one-cycle overlap on both outputs.

A digital low-pass filter stands in for the analog lock path:
- It is a saturating counter.
- The counter climbs on every sample with neither pulse active.
- It falls by a fixed step on every sample with any pulse active.
- The `lock` output has hysteresis. It sets when the count reaches an upper threshold and clears only when the count drops below a lower threshold.
- Software or a sequencer supplies both thresholds as static inputs.

Top module: `pfd_lock_top`

## Requirements
- R1: Only a low-to-high transition of `ref_in` or `fb_in` starts a pulse. A high-to-low transition, or an input held at either level, never drives `up_n` or `dn_n` low.
- R2: When `ref_in` rises and `fb_in` has not risen, `up_n` goes low on the third sample-clock rising edge after the input change, because two synchronizer stages and one flag register lie on the path. `up_n` stays low until a `fb_in` rising edge has been registered.
- R3: When `fb_in` rises first, `dn_n` behaves in the same way. It goes low on the third sample-clock edge and stays low until a `ref_in` rising edge is registered.
- R4: When both outputs are low in the same cycle, both return high on the next sample edge. Edges that reach the detector in the same sample cycle therefore drive both outputs low for exactly one cycle.
- R5: Suppose the leading input rises d sample cycles before the trailing input, with d ≥ 1. The leading output is then low for d+1 consecutive cycles, and the trailing output is low for exactly 1 cycle.
- R6: The lock counter has `CNT_W` bits.
  - On a sample where both outputs are high, it increments and saturates at all ones.
  - On a sample where either output is low, it decreases by `DECAY_STEP` and saturates at zero.
  - Reset clears it to 0.
- R7: `lock` sets on the edge after the counter is found greater than or equal to `hi_thr`. With both inputs held low after reset, `lock` is therefore 0 after `hi_thr` sample edges and 1 after `hi_thr`+1 edges.
- R8: Once set, `lock` clears only on the edge after the counter is found below `lo_thr`. Start from a saturated counter and let one output stay low continuously from sample edge e. Then `lock` is still 1 while the counter sits between `lo_thr` and `hi_thr`, and it falls at edge e + floor((2^CNT_W − 1 − `lo_thr`)/`DECAY_STEP`) + 2.
- R9: A synchronous active-low reset forces `up_n`=1, `dn_n`=1 and `lock`=0 on the next sample edge, and clears the counter.
- R10: When the reference frequency is higher than the feedback frequency, `up_n` spends more cycles low than `dn_n`. Every low run of `dn_n` then lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, faster than both compared inputs |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Divided reference wave (asynchronous) |
| fb_in | input | 1 | Divided feedback wave (asynchronous) |
| hi_thr | input | CNT_W | Counter level at or above which lock is declared |
| lo_thr | input | CNT_W | Counter level below which lock is withdrawn |
| up_n | output | 1 | Active-low request for higher oscillator frequency |
| dn_n | output | 1 | Active-low request for lower oscillator frequency |
| lock | output | 1 | Filtered lock indication, active high |

## Verification
The assertions take for granted that each compared input holds every level for at least a few sample cycles, so that an edge strobe is never swallowed by the synchronizer. They also assume that the thresholds are static, with `lo_thr` at or below `hi_thr`. The stimulus meets these conditions in three ways. It changes inputs only on the falling sample edge. It keeps both waves at periods of twenty cycles or more. It holds the thresholds constant for the whole run. The expected widths and lock instants are derived from the pipeline depth and from the counter arithmetic stated in the requirements.

// File: rtl/pfd_pkg.sv
// Package pfd_pkg
// Shared types for the phase-frequency detector block.
package pfd_pkg;

    // Pair of internal correction flags, active high.
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

endpackage

// File: rtl/pfd_edge_det.sv
// Module pfd_edge_det
// Brings one asynchronous square wave into the sample domain through
// STAGES flops, then strobes rise_o for one cycle on each low-to-high
// transition. Assumes the wave holds each level for more than STAGES+1
// sample cycles. Latency from input change to strobe: STAGES edges.
module pfd_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wave_i,
    output logic rise_o
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // Capture the raw asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= wave_i;
                end
            end else begin : g_next
                // Pass the value down the synchronizer chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // Remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[STAGES-1];
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pfd_flag_core.sv
// Module pfd_flag_core
// Two-flag reset-style detector. A reference strobe sets the up flag and
// a feedback strobe sets the dn flag. When both flags are set they clear
// together on the next cycle, and a strobe arriving in that clearing cycle
// re-arms its own flag so that no edge is lost. Assumes single-cycle
// strobes.
module pfd_flag_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise_i,
    input  logic       fb_rise_i,
    output pfd_flags_t flags_o
);

    pfd_flags_t flags_q;
    pfd_flags_t flags_d;
    logic       both_set;

    assign both_set = flags_q.up & flags_q.dn;

    // Next flag state: set on strobe, clear both once both are pending.
    always_comb begin
        if (both_set) begin
            flags_d.up = ref_rise_i;
            flags_d.dn = fb_rise_i;
        end else begin
            flags_d.up = flags_q.up | ref_rise_i;
            flags_d.dn = flags_q.dn | fb_rise_i;
        end
    end

    // Register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/pfd_lock_filter.sv
// Module pfd_lock_filter
// Digital low-pass filter for lock indication. A saturating counter rises
// by one per quiet sample and falls by DECAY_STEP per busy sample. lock_o
// sets when the count is at or above hi_thr_i and clears when it is below
// lo_thr_i. Assumes static thresholds with lo_thr_i <= hi_thr_i.
module pfd_lock_filter #(
    parameter int CNT_W      = 8,
    parameter int DECAY_STEP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             busy_i,
    input  logic [CNT_W-1:0] hi_thr_i,
    input  logic [CNT_W-1:0] lo_thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lock_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] STEP    = CNT_W'(DECAY_STEP);

    logic [CNT_W-1:0] cnt_q;
    logic             lock_q;

    // Saturating up/down count of quiet versus busy samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!busy_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end else begin
            if (cnt_q < STEP) cnt_q <= '0;
            else              cnt_q <= cnt_q - STEP;
        end
    end

    // Hysteresis comparator on the registered count.
    always_ff @(posedge clk) begin
        if (!rst_n)                           lock_q <= 1'b0;
        else if (!lock_q && cnt_q >= hi_thr_i) lock_q <= 1'b1;
        else if (lock_q && cnt_q < lo_thr_i)   lock_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign lock_o = lock_q;

endmodule

// File: rtl/pfd_lock_top.sv
// Module pfd_lock_top
// Phase-frequency detector with lock indication. Synchronizes and
// edge-detects both inputs, runs the two-flag detector, and drives the
// active-low up/down outputs straight from the flags. The lock filter
// watches both outputs. Assumes inputs much slower than clk.
module pfd_lock_top #(
    parameter int CNT_W       = 8,
    parameter int DECAY_STEP  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic [CNT_W-1:0] hi_thr,
    input  logic [CNT_W-1:0] lo_thr,
    output logic             up_n,
    output logic             dn_n,
    output logic             lock
);
    import pfd_pkg::*;

    logic             ref_rise;
    logic             fb_rise;
    pfd_flags_t       flags;
    logic [CNT_W-1:0] lock_cnt;

    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_ref_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wave_i (ref_in),
        .rise_o (ref_rise)
    );

    pfd_edge_det #(.STAGES(SYNC_STAGES)) u_fb_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .wave_i (fb_in),
        .rise_o (fb_rise)
    );

    pfd_flag_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_rise_i (ref_rise),
        .fb_rise_i  (fb_rise),
        .flags_o    (flags)
    );

    assign up_n = ~flags.up;
    assign dn_n = ~flags.dn;

    pfd_lock_filter #(.CNT_W(CNT_W), .DECAY_STEP(DECAY_STEP)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (~(up_n & dn_n)),
        .hi_thr_i (hi_thr),
        .lo_thr_i (lo_thr),
        .cnt_o    (lock_cnt),
        .lock_o   (lock)
    );

endmodule

// File: rtl/pfd_lock_chk.sv
// Module pfd_lock_chk
// Property checker for pfd_lock_top, attached by bind. Observes the
// outputs, the edge strobes and the lock counter. Assumes inputs slow
// enough that strobes are single-cycle and isolated.
module pfd_lock_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_rise,
    input logic             fb_rise,
    input logic [CNT_W-1:0] hi_thr,
    input logic [CNT_W-1:0] lo_thr,
    input logic [CNT_W-1:0] lock_cnt,
    input logic             up_n,
    input logic             dn_n,
    input logic             lock
);

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (up_n && dn_n && !lock)); // R9

    AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_n) |-> $past(ref_rise)); // R2

    AST_DN_FROM_FB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dn_n) |-> $past(fb_rise)); // R3

    AST_BOTH_CLEAR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !dn_n && !ref_rise) |=> up_n); // R4

    AST_BOTH_CLEAR_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && !dn_n && !fb_rise) |=> dn_n); // R4

    AST_UP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!up_n && dn_n) |=> !up_n); // R5

    AST_CNT_QUIET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_n && dn_n && lock_cnt != '1) |=> (lock_cnt == $past(lock_cnt) + 1'b1)); // R6

    AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> ($past(lock_cnt) >= $past(hi_thr))); // R7

    AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock) |-> ($past(lock_cnt) < $past(lo_thr))); // R8

endmodule

bind pfd_lock_top pfd_lock_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_rise (ref_rise),
    .fb_rise  (fb_rise),
    .hi_thr   (hi_thr),
    .lo_thr   (lo_thr),
    .lock_cnt (lock_cnt),
    .up_n     (up_n),
    .dn_n     (dn_n),
    .lock     (lock)
);

// File: tb/pfd_lock_top_tb_top.sv
// Directed bench for pfd_lock_top. Inputs change and outputs are read on
// the falling clock edge.
module pfd_lock_top_tb_top;

    localparam int CNT_W   = 8;
    localparam int STEP    = 4;
    localparam int HI      = 40;
    localparam int LO      = 20;
    localparam int CNT_MAX = (1 << CNT_W) - 1;
    localparam int LAT     = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_in = 1'b0;
    logic             fb_in = 1'b0;
    logic [CNT_W-1:0] hi_thr = CNT_W'(HI);
    logic [CNT_W-1:0] lo_thr = CNT_W'(LO);
    logic             up_n, dn_n, lock;

    int n_vec = 0;
    int n_bad = 0;

    always #5ns clk = ~clk;

    pfd_lock_top #(.CNT_W(CNT_W), .DECAY_STEP(STEP), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .hi_thr(hi_thr), .lo_thr(lo_thr),
        .up_n(up_n), .dn_n(dn_n), .lock(lock)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R9: outputs idle after reset.
    task automatic t_reset();
        do_reset();
        chk(up_n == 1'b1, "R9 up_n after reset", int'(up_n), 1);
        chk(dn_n == 1'b1, "R9 dn_n after reset", int'(dn_n), 1);
        chk(lock == 1'b0, "R9 lock after reset", int'(lock), 0);
    endtask

    // R7: lock acquisition time with quiet inputs.
    task automatic t_acquire();
        do_reset();
        for (int i = 1; i <= HI + 1; i++) begin
            @(negedge clk);
            if (i == HI)     chk(lock == 1'b0, "R7 lock still low at hi_thr edges", int'(lock), 0);
            if (i == HI + 1) chk(lock == 1'b1, "R7 lock high at hi_thr+1 edges", int'(lock), 1);
        end
    endtask

    // R2 R3 R4 R5: one edge pair with offset d, leader chosen by ref_first.
    task automatic t_pulse(input bit ref_first, input int d, input string req);
        int lead_low, trail_low, first_low;
        lead_low = 0; trail_low = 0; first_low = -1;
        do_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i <= d + 20; i++) begin
            if (i > 0) begin
                logic lead_n, trail_n;
                lead_n  = ref_first ? up_n : dn_n;
                trail_n = ref_first ? dn_n : up_n;
                if (!lead_n) begin
                    lead_low++;
                    if (first_low < 0) first_low = i;
                end
                if (!trail_n) trail_low++;
            end
            if (i == 0) begin
                if (ref_first) ref_in = 1'b1; else fb_in = 1'b1;
            end
            if (i == d) begin
                if (ref_first) fb_in = 1'b1; else ref_in = 1'b1;
            end
            @(negedge clk);
        end
        chk(first_low == LAT, {req, " leading output latency"}, first_low, LAT);
        if (d == 0) begin
            chk(lead_low == 1, "R4 simultaneous edges, first output width", lead_low, 1);
            chk(trail_low == 1, "R4 simultaneous edges, second output width", trail_low, 1);
        end else begin
            chk(lead_low == d + 1, {req, " R5 leading width"}, lead_low, d + 1);
            chk(trail_low == 1, {req, " R5 trailing width"}, trail_low, 1);
        end
    endtask

    // R1: falling edges and held levels give no pulses.
    task automatic t_edges_only();
        int lows;
        lows = 0;
        do_reset();
        @(negedge clk); ref_in = 1'b1; fb_in = 1'b1;
        repeat (12) @(negedge clk);
        for (int i = 0; i < 30; i++) begin
            if (i == 5)  ref_in = 1'b0;
            if (i == 14) fb_in = 1'b0;
            @(negedge clk);
            if (!up_n || !dn_n) lows++;
        end
        chk(lows == 0, "R1 falling edges and levels produce no pulse", lows, 0);
    endtask

    // R8 R2: stuck up request from a saturated counter; hysteresis and drop time.
    task automatic t_stuck();
        int kmin, i_drop;
        kmin   = (CNT_MAX - LO) / STEP + 1;
        i_drop = LAT + kmin + 1;
        do_reset();
        repeat (CNT_MAX + 10) @(negedge clk);
        chk(lock == 1'b1, "R7 lock held with quiet inputs", int'(lock), 1);
        ref_in = 1'b1;
        for (int i = 1; i <= i_drop + 2; i++) begin
            @(negedge clk);
            if (i == LAT) chk(up_n == 1'b0, "R2 up_n low after reference edge", int'(up_n), 0);
            if (i == LAT + ((CNT_MAX - HI) / STEP) + 3)
                chk(lock == 1'b1, "R8 lock held below hi_thr (hysteresis)", int'(lock), 1);
            if (i == i_drop - 1) chk(lock == 1'b1, "R8 lock still set before drop", int'(lock), 1);
            if (i == i_drop)     chk(lock == 1'b0, "R8 lock cleared below lo_thr", int'(lock), 0);
        end
        chk(up_n == 1'b0, "R2 up_n held until feedback edge", int'(up_n), 0);
    endtask

    // R10: reference faster than feedback.
    task automatic t_freq();
        int up_low, dn_low, run, max_run;
        up_low = 0; dn_low = 0; run = 0; max_run = 0;
        do_reset();
        for (int i = 0; i < 1040; i++) begin
            ref_in = ((i % 20) < 10);
            fb_in  = ((i % 26) < 13);
            @(negedge clk);
            if (!up_n) up_low++;
            if (!dn_n) begin
                dn_low++; run++;
                if (run > max_run) max_run = run;
            end else run = 0;
        end
        chk(up_low > dn_low, "R10 up requests dominate", up_low, dn_low);
        chk(max_run == 1, "R10 dn_n runs are single cycle", max_run, 1);
    endtask

    initial begin
        t_reset();
        t_acquire();
        t_pulse(1'b1, 5, "R2 ref leads by 5");
        t_pulse(1'b0, 3, "R3 fb leads by 3");
        t_pulse(1'b1, 10, "R2 ref leads by 10");
        t_pulse(1'b1, 0, "R4 simultaneous");
        t_edges_only();
        t_stuck();
        t_freq();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1ms;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule